// File: doc/BRIEF.md
# Message-Signaled Interrupt File

This block keeps the interrupt state of one hart-side interrupt file. The file has one or more pages, and each page serves one privilege or guest context. Each page holds a pending bit and an enable bit for every interrupt identity, a one-bit delivery switch and a threshold. A device raises an interrupt by writing the identity number as a 32-bit message into the page's 4 KiB window. The block decodes that write and sets the matching pending bit.

For each page, a selector finds the smallest identity that is pending, enabled and within the threshold window. That identity is the page's top interrupt. Software reaches the state through a simple register port, addressed by page and selector. Reading the top-interrupt selector returns the winner. Writing it claims the winner, which clears its pending bit. Each page drives one interrupt line. The line is high while delivery is on and a top interrupt exists.

Top module: `msi_file`

## Requirements
- R1: After reset, every pending bit, enable bit, delivery bit and threshold is zero, every register read returns 0, and every `irq_o` bit is low.
- R2: A message write is honoured when it is a full 32-bit access (`msg_full_i` high) to address `p*4096` with page `p` below PAGES and data `v` with 1 <= v <= ID_MAX. It sets the pending bit of identity `v` on page `p`.
- R3: A message write has no effect when its data is 0 or above ID_MAX, when its address is not at offset 0 of a page (this includes misaligned addresses), when it is not a full word, or when its page is PAGES or higher.
- R4: An identity is eligible only when its pending and enable bits are both set. The top interrupt is the smallest eligible identity. Identity 0 is never eligible.
- R5: The threshold (selector 0x01) keeps bits 10:0 of a masked write. When it is nonzero and no larger than ID_MAX+1, only identities strictly below it can win. Otherwise every identity can win.
- R6: A read of selector 0x02 returns `(id << 16) | id` for the top identity, or 0 when no identity is eligible.
- R7: A write to selector 0x02 ignores its data and mask and clears the pending bit of the current top identity. When there is no top identity, the write changes nothing.
- R8: `irq_o[p]` is high exactly when page p's delivery bit (selector 0x00, only bit 0 writable) is 1 and page p has a top interrupt.
- R9: Selector 0x40+k reads pending word k and selector 0x80+k reads enable word k. Bit b of word k is identity 32k+b. A write updates only the bits set in `reg_wmask_i`. A read returns the value before any write in the same cycle. Bit 0 of word 0 is always 0. Words k >= (ID_MAX+1)/32 and unused selectors read 0 and ignore writes.
- R10: When a message write sets a pending bit in the same cycle as a claim or a register write clears that bit, the bit ends up set.
- R11: Pages are independent. A message or register access to one page leaves every other page's state and line unchanged.
- R12: `irq_o` and the register read data reflect a state change in the cycle right after the clock edge that made the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| msg_we_i | input | 1 | Message write strobe |
| msg_addr_i | input | 32 | Message byte address relative to the file base |
| msg_full_i | input | 1 | Access is a full 32-bit word |
| msg_data_i | input | 32 | Message data (identity number) |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | Register access is a write |
| reg_page_i | input | PG_W | Target page |
| reg_sel_i | input | 8 | Register selector |
| reg_wdata_i | input | 32 | Register write data |
| reg_wmask_i | input | 32 | Register write bit mask |
| reg_rdata_o | output | 32 | Register read data (old value, combinational) |
| irq_o | output | PAGES | Interrupt line per page |

## Verification
The assertions check four things on every cycle: the winner is always a pending, enabled, nonzero identity below an active threshold; a claim clears the bit it claimed unless a message sets it again in that cycle; an accepted message leaves its bit set; and misaligned or zero-valued messages are never accepted. The bench scenarios are the only check of the ordering between identities and of the exact threshold boundary (equal to the threshold, equal to ID_MAX+1, above it). They also cover the field packing of the top value, the mask behaviour and the read-only bit of the word registers, the range of selectors that are ignored, and the isolation between pages.

// File: rtl/msi_file_pkg.sv
package msi_file_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int TOP_SHIFT  = 16;
  localparam int ID_FIELD_W = 11;
  localparam int WORD_W     = 32;

  localparam logic [7:0] SEL_DELIV = 8'h00;
  localparam logic [7:0] SEL_THR   = 8'h01;
  localparam logic [7:0] SEL_TOP   = 8'h02;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_DELIV,
    ACC_THR,
    ACC_TOP,
    ACC_PEND,
    ACC_EN
  } acc_kind_e;

  function automatic acc_kind_e sel_kind(input logic [7:0] sel);
    if (sel == SEL_DELIV)        return ACC_DELIV;
    else if (sel == SEL_THR)     return ACC_THR;
    else if (sel == SEL_TOP)     return ACC_TOP;
    else if (sel[7:6] == 2'b01)  return ACC_PEND;
    else if (sel[7:6] == 2'b10)  return ACC_EN;
    else                         return ACC_NONE;
  endfunction
endpackage

// File: rtl/msi_prio_lowest.sv
module msi_prio_lowest #(
  parameter int W = 64,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        vld_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/msi_msg_decode.sv
module msi_msg_decode #(
  parameter int PAGES  = 2,
  parameter int ID_MAX = 63,
  localparam int N_IDS = ID_MAX + 1,
  localparam int IDW   = $clog2(N_IDS),
  localparam int PG_W  = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic            we_i,
  input  logic [31:0]     addr_i,
  input  logic            full_i,
  input  logic [31:0]     data_i,
  output logic            set_o,
  output logic [PG_W-1:0] set_page_o,
  output logic [IDW-1:0]  set_id_o
);
  import msi_file_pkg::*;

  logic [31-PAGE_SHIFT:0] page_fld;
  logic offset_zero, page_ok, data_ok;

  assign page_fld    = addr_i[31:PAGE_SHIFT];
  assign offset_zero = (addr_i[PAGE_SHIFT-1:0] == '0);
  assign page_ok     = (32'(page_fld) < 32'(PAGES));
  assign data_ok     = (data_i != '0) && (data_i < 32'(N_IDS));

  assign set_o      = we_i && full_i && offset_zero && page_ok && data_ok;
  assign set_page_o = addr_i[PAGE_SHIFT +: PG_W];
  assign set_id_o   = data_i[IDW-1:0];
endmodule

// File: rtl/msi_page.sv
module msi_page #(
  parameter int ID_MAX = 63,
  localparam int N_IDS   = ID_MAX + 1,
  localparam int IDW     = $clog2(N_IDS),
  localparam int N_WORDS = N_IDS / msi_file_pkg::WORD_W,
  localparam int LIM_W   = msi_file_pkg::ID_FIELD_W + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           acc_i,
  input  logic           we_i,
  input  logic [7:0]     sel_i,
  input  logic [31:0]    wdata_i,
  input  logic [31:0]    wmask_i,
  output logic [31:0]    rdata_o,
  input  logic           set_i,
  input  logic [IDW-1:0] set_id_i,
  output logic           irq_o
);
  import msi_file_pkg::*;

  logic [N_IDS-1:0] pend_q, pend_d, en_q, en_d, in_win, elig;
  logic             deliv_q;
  logic [ID_FIELD_W-1:0] thr_q;
  logic [LIM_W-1:0] lim;
  logic             top_vld;
  logic [IDW-1:0]   top_id;
  logic [31:0]      top_val;
  acc_kind_e        kind;
  logic [5:0]       word;
  logic             wr;

  assign kind = acc_i ? sel_kind(sel_i) : ACC_NONE;
  assign word = sel_i[5:0];
  assign wr   = acc_i && we_i;

  // threshold window: zero or oversize threshold opens the full range
  assign lim = ((thr_q != '0) && (LIM_W'(thr_q) <= LIM_W'(N_IDS))) ?
               LIM_W'(thr_q) : LIM_W'(N_IDS);

  for (genvar gi = 0; gi < N_IDS; gi++) begin : g_win
    assign in_win[gi] = (LIM_W'(gi) < lim);
  end

  assign elig = pend_q & en_q & in_win;

  msi_prio_lowest #(.W(N_IDS)) u_prio (
    .vec_i (elig),
    .vld_o (top_vld),
    .idx_o (top_id)
  );

  assign top_val = top_vld ? ((32'(top_id) << TOP_SHIFT) | 32'(top_id)) : '0;
  assign irq_o   = deliv_q && top_vld;

  always_comb begin
    rdata_o = '0;
    unique case (kind)
      ACC_DELIV: rdata_o[0] = deliv_q;
      ACC_THR:   rdata_o[ID_FIELD_W-1:0] = thr_q;
      ACC_TOP:   rdata_o = top_val;
      ACC_PEND: begin
        for (int w = 0; w < N_WORDS; w++)
          if (word == 6'(w)) rdata_o = pend_q[w*WORD_W +: WORD_W];
      end
      ACC_EN: begin
        for (int w = 0; w < N_WORDS; w++)
          if (word == 6'(w)) rdata_o = en_q[w*WORD_W +: WORD_W];
      end
      default: rdata_o = '0;
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    en_d   = en_q;
    if (wr && kind == ACC_PEND) begin
      for (int w = 0; w < N_WORDS; w++)
        for (int b = 0; b < WORD_W; b++)
          if (word == 6'(w) && wmask_i[b]) pend_d[w*WORD_W + b] = wdata_i[b];
    end
    if (wr && kind == ACC_EN) begin
      for (int w = 0; w < N_WORDS; w++)
        for (int b = 0; b < WORD_W; b++)
          if (word == 6'(w) && wmask_i[b]) en_d[w*WORD_W + b] = wdata_i[b];
    end
    if (wr && kind == ACC_TOP && top_vld) pend_d[top_id] = 1'b0;
    // message set is applied last so it wins over any clear
    if (set_i) pend_d[set_id_i] = 1'b1;
    pend_d[0] = 1'b0;
    en_d[0]   = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      en_q    <= '0;
      deliv_q <= 1'b0;
      thr_q   <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      if (wr && kind == ACC_DELIV && wmask_i[0]) deliv_q <= wdata_i[0];
      if (wr && kind == ACC_THR)
        thr_q <= (thr_q & ~wmask_i[ID_FIELD_W-1:0]) |
                 (wdata_i[ID_FIELD_W-1:0] & wmask_i[ID_FIELD_W-1:0]);
    end
  end

  p_claim_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && kind == ACC_TOP && top_vld && !(set_i && set_id_i == top_id))
      |=> !pend_q[$past(top_id)]);

  p_msg_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_q[$past(set_id_i)]);

  p_top_eligible_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_vld |-> (pend_q[top_id] && en_q[top_id] && top_id != '0));

  p_top_below_thr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_vld && thr_q != '0 && LIM_W'(thr_q) <= LIM_W'(N_IDS))
      |-> (LIM_W'(top_id) < LIM_W'(thr_q)));
endmodule

// File: rtl/msi_file.sv
module msi_file #(
  parameter int PAGES  = 2,
  parameter int ID_MAX = 63,
  localparam int N_IDS = ID_MAX + 1,
  localparam int IDW   = $clog2(N_IDS),
  localparam int PG_W  = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            msg_we_i,
  input  logic [31:0]     msg_addr_i,
  input  logic            msg_full_i,
  input  logic [31:0]     msg_data_i,
  input  logic            reg_req_i,
  input  logic            reg_we_i,
  input  logic [PG_W-1:0] reg_page_i,
  input  logic [7:0]      reg_sel_i,
  input  logic [31:0]     reg_wdata_i,
  input  logic [31:0]     reg_wmask_i,
  output logic [31:0]     reg_rdata_o,
  output logic [PAGES-1:0] irq_o
);
  logic            set_any;
  logic [PG_W-1:0] set_page;
  logic [IDW-1:0]  set_id;
  logic [31:0]     page_rdata [PAGES];

  msi_msg_decode #(.PAGES(PAGES), .ID_MAX(ID_MAX)) u_dec (
    .we_i       (msg_we_i),
    .addr_i     (msg_addr_i),
    .full_i     (msg_full_i),
    .data_i     (msg_data_i),
    .set_o      (set_any),
    .set_page_o (set_page),
    .set_id_o   (set_id)
  );

  for (genvar gp = 0; gp < PAGES; gp++) begin : g_page
    msi_page #(.ID_MAX(ID_MAX)) u_page (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .acc_i    (reg_req_i && reg_page_i == PG_W'(gp)),
      .we_i     (reg_we_i),
      .sel_i    (reg_sel_i),
      .wdata_i  (reg_wdata_i),
      .wmask_i  (reg_wmask_i),
      .rdata_o  (page_rdata[gp]),
      .set_i    (set_any && set_page == PG_W'(gp)),
      .set_id_i (set_id),
      .irq_o    (irq_o[gp])
    );
  end

  // unselected pages drive zero, so an OR merges them
  always_comb begin
    reg_rdata_o = '0;
    for (int p = 0; p < PAGES; p++) reg_rdata_o |= page_rdata[p];
  end

  p_drop_misaligned_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_we_i && msg_addr_i[1:0] != 2'b00) |-> !set_any);

  p_drop_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_we_i && msg_data_i == '0) |-> !set_any);

  p_drop_partial_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_we_i && !msg_full_i) |-> !set_any);
endmodule

// File: tb/sim_msi_file.sv
`timescale 1ns/1ps
module sim_msi_file;
  localparam int PAGES  = 2;
  localparam int ID_MAX = 63;
  localparam int PG_W   = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic msg_we = 0, msg_full = 0;
  logic [31:0] msg_addr = '0, msg_data = '0;
  logic reg_req = 0, reg_we = 0;
  logic [PG_W-1:0] reg_page = '0;
  logic [7:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0, reg_wmask = '0, reg_rdata;
  logic [PAGES-1:0] irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  msi_file #(.PAGES(PAGES), .ID_MAX(ID_MAX)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .msg_we_i(msg_we), .msg_addr_i(msg_addr), .msg_full_i(msg_full), .msg_data_i(msg_data),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_page_i(reg_page), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_wmask_i(reg_wmask), .reg_rdata_o(reg_rdata),
    .irq_o(irq)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic rd(input int pg, input logic [7:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_page = PG_W'(pg); reg_sel = sel;
    #1 d = reg_rdata;
    reg_req = 0;
  endtask

  task automatic rd_chk(input string r, input int pg, input logic [7:0] sel,
                        input logic [31:0] exp);
    logic [31:0] d;
    rd(pg, sel, d);
    chk(r, d, exp);
  endtask

  task automatic wr(input int pg, input logic [7:0] sel, input logic [31:0] data,
                    input logic [31:0] mask, output logic [31:0] old);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_page = PG_W'(pg); reg_sel = sel;
    reg_wdata = data; reg_wmask = mask;
    #1 old = reg_rdata;
    @(posedge clk); #1;
    reg_req = 0; reg_we = 0;
  endtask

  task automatic msg(input logic [31:0] addr, input logic [31:0] data, input logic full);
    @(negedge clk);
    msg_we = 1; msg_addr = addr; msg_data = data; msg_full = full;
    @(posedge clk); #1;
    msg_we = 0;
  endtask

  logic [31:0] o;

  task automatic t_reset();
    chk("R1 irq", 32'(irq), 0);
    for (int p = 0; p < PAGES; p++) begin
      rd_chk("R1 deliv", p, 8'h00, 0);
      rd_chk("R1 thr", p, 8'h01, 0);
      rd_chk("R1 top", p, 8'h02, 0);
      rd_chk("R1 pend0", p, 8'h40, 0);
      rd_chk("R1 en1", p, 8'h81, 0);
    end
  endtask

  task automatic t_msg();
    wr(0, 8'h80, 32'hFFFF_FFFF, 32'hFFFF_FFFF, o);
    wr(0, 8'h81, 32'hFFFF_FFFF, 32'hFFFF_FFFF, o);
    wr(0, 8'h00, 32'h1, 32'h1, o);
    rd_chk("R9 en0 bit0 ro", 0, 8'h80, 32'hFFFF_FFFE);
    chk("R8 no top no irq", 32'(irq), 0);
    msg(32'h0, 32'd5, 1);
    chk("R12 irq after msg", 32'(irq), 32'b01);
    rd_chk("R2 pend0", 0, 8'h40, 32'h20);
    rd_chk("R6 top", 0, 8'h02, 32'h0005_0005);
  endtask

  task automatic t_ignore();
    msg(32'h0, 32'd0, 1);
    msg(32'h0, 32'd64, 1);
    msg(32'h0, 32'hFFFF_FFFF, 1);
    msg(32'h4, 32'd7, 1);
    msg(32'h1, 32'd8, 1);
    msg(32'h0, 32'd9, 0);
    msg(32'h2000, 32'd10, 1);
    rd_chk("R3 pg0 w0", 0, 8'h40, 32'h20);
    rd_chk("R3 pg0 w1", 0, 8'h41, 0);
    rd_chk("R3 pg1 w0", 1, 8'h40, 0);
  endtask

  task automatic t_prio();
    msg(32'h0, 32'd40, 1);
    msg(32'h0, 32'd3, 1);
    rd_chk("R2 w0", 0, 8'h40, 32'h28);
    rd_chk("R9 w1 id40", 0, 8'h41, 32'h100);
    rd_chk("R4 lowest wins", 0, 8'h02, 32'h0003_0003);
    wr(0, 8'h02, 32'h0000_DEAD, 32'hFFFF_FFFF, o);
    rd_chk("R7 claim cleared", 0, 8'h40, 32'h20);
    rd_chk("R7 next top", 0, 8'h02, 32'h0005_0005);
    wr(0, 8'h81, 32'h0, 32'h100, o);
    rd_chk("R4 disabled id40", 0, 8'h41, 32'h100);
    wr(0, 8'h81, 32'h100, 32'h100, o);
  endtask

  task automatic t_thr();
    wr(0, 8'h01, 32'd5, 32'hFFFF_FFFF, o);
    rd_chk("R5 thr eq id", 0, 8'h02, 0);
    chk("R8 irq low", 32'(irq), 0);
    wr(0, 8'h01, 32'd6, 32'hFFFF_FFFF, o);
    rd_chk("R5 thr above", 0, 8'h02, 32'h0005_0005);
    wr(0, 8'h01, 32'd64, 32'hFFFF_FFFF, o);
    rd_chk("R5 thr max", 0, 8'h02, 32'h0005_0005);
    wr(0, 8'h01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, o);
    rd_chk("R5 thr mask", 0, 8'h01, 32'h7FF);
    rd_chk("R5 thr oversize", 0, 8'h02, 32'h0005_0005);
    wr(0, 8'h01, 32'd0, 32'h7F0, o);
    rd_chk("R5 masked write", 0, 8'h01, 32'h00F);
    wr(0, 8'h01, 32'd0, 32'hFFFF_FFFF, o);
  endtask

  task automatic t_deliv();
    wr(0, 8'h00, 32'h0, 32'h1, o);
    chk("R8 deliv off", 32'(irq), 0);
    rd_chk("R8 top kept", 0, 8'h02, 32'h0005_0005);
    wr(0, 8'h00, 32'h1, 32'h0, o);
    rd_chk("R8 mask zero", 0, 8'h00, 0);
    wr(0, 8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, o);
    rd_chk("R8 bit0 only", 0, 8'h00, 32'h1);
    chk("R8 deliv on", 32'(irq), 32'b01);
  endtask

  task automatic t_words();
    wr(0, 8'h41, 32'h8000_0000, 32'h8000_0000, o);
    chk("R9 old value", o, 32'h100);
    rd_chk("R9 w1 new", 0, 8'h41, 32'h8000_0100);
    wr(0, 8'h40, 32'hFFFF_FFFF, 32'h1, o);
    rd_chk("R9 bit0 ro", 0, 8'h40, 32'h20);
    wr(0, 8'h40, 32'h0, 32'h20, o);
    rd_chk("R9 masked clear", 0, 8'h40, 0);
    rd_chk("R4 top 40", 0, 8'h02, 32'h0028_0028);
    wr(0, 8'h42, 32'hFFFF_FFFF, 32'hFFFF_FFFF, o);
    rd_chk("R9 word oor", 0, 8'h42, 0);
    rd_chk("R9 en oor", 0, 8'h82, 0);
    rd_chk("R9 unused sel", 0, 8'h05, 0);
    rd_chk("R9 oor no effect", 0, 8'h02, 32'h0028_0028);
  endtask

  task automatic t_race();
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_page = 0; reg_sel = 8'h02;
    reg_wdata = 0; reg_wmask = 32'hFFFF_FFFF;
    msg_we = 1; msg_addr = 0; msg_data = 32'd40; msg_full = 1;
    @(posedge clk); #1;
    reg_req = 0; reg_we = 0; msg_we = 0;
    rd_chk("R10 set wins", 0, 8'h41, 32'h8000_0100);
    wr(0, 8'h02, 32'h0, 32'h0, o);
    rd_chk("R7 claim 40", 0, 8'h41, 32'h8000_0000);
    rd_chk("R6 top 63", 0, 8'h02, 32'h003F_003F);
  endtask

  task automatic t_pages();
    msg(32'h1000, 32'd9, 1);
    rd_chk("R11 pg1 pend", 1, 8'h40, 32'h200);
    rd_chk("R11 pg0 untouched", 0, 8'h40, 0);
    chk("R11 pg1 not enabled", 32'(irq), 32'b01);
    wr(1, 8'h80, 32'h200, 32'h200, o);
    wr(1, 8'h00, 32'h1, 32'h1, o);
    chk("R11 both lines", 32'(irq), 32'b11);
    rd_chk("R11 pg1 top", 1, 8'h02, 32'h0009_0009);
    rd_chk("R11 pg0 top", 0, 8'h02, 32'h003F_003F);
    rd_chk("R11 pg0 en", 0, 8'h80, 32'hFFFF_FFFE);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_msg();
    t_ignore();
    t_prio();
    t_thr();
    t_deliv();
    t_words();
    t_race();
    t_pages();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule